// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage with Dual-Cycle Deselect

This block is the data output stage of a synchronous SRAM. Each clock it samples a command (hold, read, write or deselect). It takes the word the memory array presents and drives a data bus, modelled as a value plus a drive enable. A static mode input selects the timing. In flow-through timing the array word goes straight to the bus. In pipelined timing a rising-edge output register sits between the array and the bus, which adds one clock of read latency.

In pipelined timing a deselect passes through the same two register stages as a read. The bus therefore stays driven for one full cycle after the deselect edge and turns off only after the following edge. An output-enable input gates the drivers combinationally, with no clock involved. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `rdout_stage`

## Requirements
- R1: Command encoding on `cmd_i`: 2'b00 hold, 2'b01 read, 2'b10 write, 2'b11 deselect. With `pipe_mode_i` low (flow-through), a read sampled at edge k drives the bus in the cycle after edge k, and `dq_o` equals `arr_data_i` of that same cycle.
- R2: With `pipe_mode_i` high (pipelined), a read sampled at edge k makes the output register capture `arr_data_i` at edge k+1, and that word drives the bus in the cycle after edge k+1.
- R3: In pipelined timing, a deselect sampled at edge k that follows a read leaves the bus driven through the cycle after edge k and turns it off after edge k+1. In flow-through timing the bus turns off right after edge k.
- R4: A write sampled at edge k never drives the bus in the slot it occupies: the cycle after edge k in flow-through timing, or the cycle after edge k+1 in pipelined timing.
- R5: A hold command keeps the previous read or idle state. After a read, holds keep the bus driven, and in pipelined timing the output register keeps loading the array word every clock.
- R6: When `oe_i` is low, `dq_oe_o` is low immediately, without waiting for a clock edge. When `oe_i` rises again, the pipelined state shows through at once.
- R7: While `rst_n` is low, `dq_oe_o` is low at once. Commands have no effect until two clock edges after `rst_n` rises.
- R8: Back-to-back reads put one new array word on the bus every clock, in either timing mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe_mode_i | input | 1 | Static timing select: 1 pipelined, 0 flow-through |
| oe_i | input | 1 | Output enable, active high, not clocked |
| cmd_i | input | 2 | Per-cycle command (hold, read, write, deselect) |
| arr_data_i | input | DATA_W | Word presented by the memory array |
| dq_o | output | DATA_W | Bus value, meaningful when `dq_oe_o` is high |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
On every clock the assertions check the read latency in both modes, the same-cycle data path in flow-through timing, and the captured word in pipelined timing. They also check that the bus stays on for a cycle after a deselect and then turns off, and that writes, a low output enable and reset keep the bus quiet. Some behaviours only the bench scenarios can show. These are the effect of `oe_i` changing in the middle of a cycle, and the bus turning off at once when reset is asserted in the middle of a burst. The rest are streams of back-to-back reads, read/write interleaving, and long hold runs compared against the behavioural model.

// File: rtl/rdout_pkg.sv
package rdout_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_DESEL = 2'b11
  } rd_cmd_e;
endpackage

// File: rtl/rdout_rst_sync.sv
module rdout_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rdout_cmd_reg.sv
// First stage: turns the command stream into a registered read-valid flag.
module rdout_cmd_reg
  import rdout_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic [1:0] cmd_i,
  output logic       rd_q
);
  logic rd_d;

  always_comb begin
    unique case (rd_cmd_e'(cmd_i))
      CMD_READ:  rd_d = 1'b1;
      CMD_WRITE: rd_d = 1'b0;
      CMD_DESEL: rd_d = 1'b0;
      default:   rd_d = rd_q;   // hold keeps the slot as it was
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rd_q <= 1'b0;
    else         rd_q <= rd_d;
  end
endmodule

// File: rtl/rdout_data_reg.sv
// Second stage: output register; valid follows stage one, data loads only on a read slot.
module rdout_data_reg #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              rd_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              rd_q,
  output logic [DATA_W-1:0] data_q
);
  logic              load_en;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    load_en = rd_in;
    data_d  = load_en ? data_in : data_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_q   <= 1'b0;
      data_q <= '0;
    end else begin
      rd_q   <= rd_in;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/rdout_stage.sv
module rdout_stage #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode_i,
  input  logic              oe_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              srst_n;
  logic              s1_rd;
  logic              s2_rd;
  logic [DATA_W-1:0] s2_data;
  logic              slot_rd;

  rdout_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rdout_cmd_reg u_cmd (
    .clk    (clk),
    .srst_n (srst_n),
    .cmd_i  (cmd_i),
    .rd_q   (s1_rd)
  );

  rdout_data_reg #(.DATA_W(DATA_W)) u_dat (
    .clk     (clk),
    .srst_n  (srst_n),
    .rd_in   (s1_rd),
    .data_in (arr_data_i),
    .rd_q    (s2_rd),
    .data_q  (s2_data)
  );

  always_comb begin
    slot_rd = pipe_mode_i ? s2_rd   : s1_rd;
    dq_o    = pipe_mode_i ? s2_data : arr_data_i;
    dq_oe_o = slot_rd & oe_i;
  end
endmodule

// File: rtl/rdout_chk.sv
module rdout_chk
  import rdout_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              srst_n,
  input logic              pipe_mode_i,
  input logic              oe_i,
  input logic [1:0]        cmd_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o
);
  logic [1:0] age;
  logic       armed;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign armed = (age == 2'd3);

  AST_FT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!srst_n)
    armed && !pipe_mode_i && oe_i && $past(cmd_i) == CMD_READ |-> dq_oe_o && dq_o == arr_data_i); // R1
  AST_PIPE_REG_DATA: assert property (@(posedge clk) disable iff (!srst_n)
    armed && pipe_mode_i && oe_i && $past(cmd_i, 2) == CMD_READ |-> dq_oe_o && dq_o == $past(arr_data_i)); // R2
  AST_DCD_STILL_ON: assert property (@(posedge clk) disable iff (!srst_n)
    armed && pipe_mode_i && oe_i && $past(cmd_i) == CMD_DESEL && $past(cmd_i, 2) == CMD_READ |-> dq_oe_o); // R3
  AST_DCD_OFF: assert property (@(posedge clk) disable iff (!srst_n)
    armed && pipe_mode_i && $past(cmd_i, 2) == CMD_DESEL |-> !dq_oe_o); // R3
  AST_PIPE_WR_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    armed && pipe_mode_i && $past(cmd_i, 2) == CMD_WRITE |-> !dq_oe_o); // R4
  AST_FT_WR_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    armed && !pipe_mode_i && $past(cmd_i) == CMD_WRITE |-> !dq_oe_o); // R4
  AST_OE_GATES: assert property (@(posedge clk)
    !oe_i |-> !dq_oe_o); // R6
  AST_RST_QUIET: assert property (@(posedge clk)
    !srst_n |-> !dq_oe_o); // R7
endmodule

bind rdout_stage rdout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .pipe_mode_i (pipe_mode_i),
  .oe_i        (oe_i),
  .cmd_i       (cmd_i),
  .arr_data_i  (arr_data_i),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o)
);

// File: tb/tb_rdout_stage.sv
`timescale 1ns/1ps
module tb_rdout_stage;
  localparam int W = 36;
  localparam logic [1:0] HLD = 2'b00, RD = 2'b01, WR = 2'b10, DS = 2'b11;

  logic clk = 1'b0;
  logic rst_n, pipe, oe;
  logic [1:0] cmd;
  logic [W-1:0] arr, dq;
  logic dq_oe;

  always #4 clk = ~clk;

  rdout_stage #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode_i(pipe), .oe_i(oe),
    .cmd_i(cmd), .arr_data_i(arr), .dq_o(dq), .dq_oe_o(dq_oe));

  int checks = 0, errors = 0, rel = 0;
  bit done = 1'b0;
  bit m_valid [$];          // read-valid history, newest first
  logic [W-1:0] m_word;     // word held for the bus in pipelined timing
  bit m_now;                // latest issued read state

  // Behavioural reference: each edge pushes the current read state into a history.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = '{0, 0}; m_now = 0; m_word = '0; rel = 0;
    end else begin
      if (rel >= 2) begin
        if (m_valid[0]) m_word = arr;
        if (cmd == RD) m_now = 1;
        else if (cmd == WR || cmd == DS) m_now = 0;
        m_valid.push_front(m_now);
        void'(m_valid.pop_back());
      end
      rel++;
    end
  end

  task automatic check_out(string req);
    bit eo;
    logic [W-1:0] ed;
    eo = oe && (pipe ? m_valid[1] : m_valid[0]);
    ed = pipe ? m_word : arr;
    checks++;
    if (dq_oe !== eo) begin
      errors++;
      $display("FAIL %s: dq_oe_o=%0b expected %0b (t=%0t)", req, dq_oe, eo, $time);
    end else if (eo && dq !== ed) begin
      errors++;
      $display("FAIL %s: dq_o=%h expected %h (t=%0t)", req, dq, ed, $time);
    end
  endtask

  task automatic cyc(logic [1:0] c, int v, string req);
    @(posedge clk); #1;
    cmd = c; arr = W'(v); #2;
    check_out(req);
  endtask

  task automatic do_reset(bit mode);
    @(posedge clk); #1;
    rst_n = 0; pipe = mode; cmd = HLD; oe = 1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 4; i++) cyc(HLD, 16'hA000 + i, "R7");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pipe = 0; oe = 1; cmd = HLD; arr = '0;
    m_valid = '{0, 0};
    #3;
    checks++;
    if (dq_oe !== 1'b0) begin errors++; $display("FAIL R7: dq_oe_o=%0b expected 0 at reset", dq_oe); end
    for (int m = 0; m < 2; m++) begin
      string lat;
      lat = (m == 1) ? "R2" : "R1";
      do_reset(m[0]);
      // single read then holds (R1/R2, R5)
      cyc(RD, 32'h111, lat);
      for (int i = 0; i < 4; i++) cyc(HLD, 32'h200 + i, "R5");
      // deselect travels the read pipeline (R3)
      cyc(DS, 32'h300, "R3");
      for (int i = 0; i < 3; i++) cyc(HLD, 32'h310 + i, "R3");
      // streaming reads (R8)
      for (int i = 0; i < 6; i++) cyc(RD, 32'h4000 + 7 * i, "R8");
      cyc(DS, 32'h4100, "R3");
      cyc(HLD, 32'h4101, "R3");
      cyc(HLD, 32'h4102, "R3");
      // writes stay quiet (R4)
      cyc(WR, 32'h500, "R4");
      for (int i = 0; i < 3; i++) cyc(HLD, 32'h510 + i, "R4");
      cyc(RD, 32'h520, "R4");
      cyc(WR, 32'h521, "R4");
      cyc(RD, 32'h522, "R4");
      cyc(WR, 32'h523, "R4");
      cyc(HLD, 32'h524, "R4");
      cyc(HLD, 32'h525, "R4");
      // output enable acts without a clock (R6)
      cyc(RD, 32'h600, lat);
      cyc(HLD, 32'h601, "R6");
      cyc(HLD, 32'h602, "R6");
      #1 oe = 0; #1;
      checks++;
      if (dq_oe !== 1'b0) begin errors++; $display("FAIL R6: dq_oe_o=%0b expected 0", dq_oe); end
      #1 oe = 1; #0.5;
      check_out("R6");
      cyc(HLD, 32'h603, "R6");
      // reset in the middle of a burst (R7)
      cyc(RD, 32'h700, "R8");
      cyc(RD, 32'h701, "R8");
      #1 rst_n = 0; #1;
      checks++;
      if (dq_oe !== 1'b0) begin errors++; $display("FAIL R7: dq_oe_o=%0b expected 0 in reset", dq_oe); end
      @(posedge clk); #1 rst_n = 1;
      cyc(RD, 32'h710, "R7");   // ignored: internal reset still held
      cyc(HLD, 32'h711, "R7");
      cyc(HLD, 32'h712, "R7");
      cyc(HLD, 32'h713, "R7");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule